// File: doc/BRIEF.md
# Phase-Continuous Binary FSK Modulator

This block serialises a 32-bit word into a binary frequency-shift-keyed sample stream. Two numerically controlled tones run side by side, each driven by its own phase accumulator and frequency-control word. For each data bit the output picks one of the two tones: a one takes the higher tone and a zero takes the lower tone. Both accumulators advance on every clock, whatever the data, so a tone change only moves the output onto a phase that was already running. No phase is restarted at a bit boundary.

A single start pulse captures the data word, both frequency-control words and the bit duration. The word is sent most significant bit first. Each bit lasts a programmable number of clocks. Every sample is taken from a 64-point, 8-bit signed sine table, addressed by the top six bits of the selected accumulator. No multiplier is used. When the last bit ends, a one-cycle done pulse is raised and the output returns to zero until the next start.

Top module: `fsk_tx`

## Requirements
- R1: While reset is asserted, and in the first idle cycle after it, `sample_o`, `bit_o`, `busy_o` and `done_o` are all zero. Reset acts asynchronously.
- R2: A `start_i` sampled high while idle latches `data_i`, `fcw_hi_i`, `fcw_lo_i` and `bit_len_i`. From the next cycle `busy_o` is high and `bit_o` shows bit 31 of the latched word.
- R3: Bits leave most significant first. Each bit lasts the latched bit length in clocks, and `busy_o` stays high for exactly 32 × length cycles.
- R4: While busy, `sample_o` equals round(127·sin(2πk/64)), in two's complement. Here k is bits [15:10] of the high-tone accumulator when the current bit is 1, and of the low-tone accumulator when it is 0.
- R5: Both accumulators start at zero after reset. On every clock, busy or idle, each adds its latched frequency-control word modulo 2^16, so that a tone change causes no phase restart.
- R6: `done_o` is high for exactly one cycle, the first cycle after the last sample of bit 0. In that cycle `busy_o` is already low. While idle, `sample_o` and `bit_o` are zero.
- R7: A `start_i` pulse while busy has no effect. Changes on the data, frequency and length inputs while busy do not alter the frame in flight.
- R8: A start given during the done cycle is accepted, so frames can run back to back with no gap cycle.
- R9: A bit length of 0 is treated as 1 clock per bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame start request, honoured only while idle |
| data_i | input | 32 | Word to transmit, MSB first |
| fcw_hi_i | input | 16 | Frequency-control word of the high tone |
| fcw_lo_i | input | 16 | Frequency-control word of the low tone |
| bit_len_i | input | 8 | Clocks per bit (0 means 1) |
| sample_o | output | 8 | Signed sine sample of the selected tone, zero when idle |
| bit_o | output | 1 | Data bit now being sent |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse after the final bit |

## Verification
The done pulse of one frame and the acceptance of the next start can fall in the same cycle. The bench provokes this by raising `start_i` in the very cycle it sees `done_o`. It then expects `busy_o` back high one cycle later, with no idle gap, and expects the new word's first bit on `bit_o`. A second overlap is an ignored start landing in the middle of a frame while the inputs change. A cycle-by-cycle reference model judges both cases. It keeps its own free-running accumulators and computes its own sine values, and it must agree with every output sample through the switch.

// File: rtl/fsk_pkg.sv
package fsk_pkg;
  localparam int unsigned FRAME_BITS = 32;
  localparam int unsigned LUT_AW     = 6;
  localparam int unsigned SAMP_W     = 8;
  localparam int unsigned NUM_TONES  = 2;
  typedef enum logic {TONE_LO = 1'b0, TONE_HI = 1'b1} tone_e;
endpackage

// File: rtl/fsk_phase_acc.sv
module fsk_phase_acc #(
  parameter int unsigned ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [ACC_W-1:0] fcw_i,
  output logic [ACC_W-1:0] phase_o
);
  logic [ACC_W-1:0] phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (en_i) phase_d = phase_q + fcw_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/fsk_sine_lut.sv
module fsk_sine_lut
  import fsk_pkg::*;
(
  input  logic [LUT_AW-1:0]        addr_i,
  output logic signed [SAMP_W-1:0] sample_o
);
  localparam int unsigned QW = LUT_AW - 2;
  localparam int unsigned QN = 1 << QW;

  logic [1:0]        quad;
  logic [QW-1:0]     off;
  logic [QW:0]       qidx;
  logic [SAMP_W-1:0] mag;

  assign quad = addr_i[LUT_AW-1 -: 2];
  assign off  = addr_i[QW-1:0];

  always_comb begin
    if (quad[0]) qidx = (QW+1)'(QN) - {1'b0, off};
    else         qidx = {1'b0, off};
  end

  always_comb begin
    case (qidx)
      5'd0:    mag = 8'd0;
      5'd1:    mag = 8'd12;
      5'd2:    mag = 8'd25;
      5'd3:    mag = 8'd37;
      5'd4:    mag = 8'd49;
      5'd5:    mag = 8'd60;
      5'd6:    mag = 8'd71;
      5'd7:    mag = 8'd81;
      5'd8:    mag = 8'd90;
      5'd9:    mag = 8'd98;
      5'd10:   mag = 8'd106;
      5'd11:   mag = 8'd112;
      5'd12:   mag = 8'd117;
      5'd13:   mag = 8'd122;
      5'd14:   mag = 8'd125;
      5'd15:   mag = 8'd126;
      default: mag = 8'd127;
    endcase
  end

  always_comb begin
    if (quad[1]) sample_o = -$signed(mag);
    else         sample_o = $signed(mag);
  end
endmodule

// File: rtl/fsk_bit_seq.sv
module fsk_bit_seq #(
  parameter int unsigned BITS  = 32,
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [BITS-1:0]  data_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             bit_o,
  output logic             done_o
);
  localparam int unsigned CNT_W = $clog2(BITS);

  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [BITS-1:0]  sh_q, sh_d;
  logic [LEN_W-1:0] scnt_q, scnt_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [CNT_W-1:0] bcnt_q, bcnt_d;
  logic             last_samp, last_bit;

  assign last_samp = (scnt_q == len_q - LEN_W'(1));
  assign last_bit  = (bcnt_q == CNT_W'(BITS-1));
  assign accept_o  = start_i & ~busy_q;

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    sh_d   = sh_q;
    scnt_d = scnt_q;
    bcnt_d = bcnt_q;
    len_d  = len_q;
    if (busy_q) begin
      if (last_samp) begin
        scnt_d = '0;
        if (last_bit) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end else begin
          bcnt_d = bcnt_q + CNT_W'(1);
          sh_d   = {sh_q[BITS-2:0], 1'b0};
        end
      end else begin
        scnt_d = scnt_q + LEN_W'(1);
      end
    end else if (start_i) begin
      busy_d = 1'b1;
      sh_d   = data_i;
      scnt_d = '0;
      bcnt_d = '0;
      len_d  = (len_i == '0) ? LEN_W'(1) : len_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sh_q   <= '0;
      scnt_q <= '0;
      bcnt_q <= '0;
      len_q  <= LEN_W'(1);
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      sh_q   <= sh_d;
      scnt_q <= scnt_d;
      bcnt_q <= bcnt_d;
      len_q  <= len_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign bit_o  = busy_q & sh_q[BITS-1];
endmodule

// File: rtl/fsk_tx.sv
module fsk_tx
  import fsk_pkg::*;
#(
  parameter int unsigned ACC_W = 16,
  parameter int unsigned LEN_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [FRAME_BITS-1:0]    data_i,
  input  logic [ACC_W-1:0]         fcw_hi_i,
  input  logic [ACC_W-1:0]         fcw_lo_i,
  input  logic [LEN_W-1:0]         bit_len_i,
  output logic signed [SAMP_W-1:0] sample_o,
  output logic                     bit_o,
  output logic                     busy_o,
  output logic                     done_o
);
  logic                  accept;
  logic [ACC_W-1:0]      fcw_q [NUM_TONES];
  logic [ACC_W-1:0]      fcw_d [NUM_TONES];
  logic [ACC_W-1:0]      phase [NUM_TONES];
  logic [ACC_W-1:0]      fcw_in[NUM_TONES];
  logic [LUT_AW-1:0]     lut_addr;
  logic signed [SAMP_W-1:0] lut_val;
  tone_e                 tone_sel;

  assign fcw_in[TONE_LO] = fcw_lo_i;
  assign fcw_in[TONE_HI] = fcw_hi_i;

  fsk_bit_seq #(.BITS(FRAME_BITS), .LEN_W(LEN_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .data_i   (data_i),
    .len_i    (bit_len_i),
    .accept_o (accept),
    .busy_o   (busy_o),
    .bit_o    (bit_o),
    .done_o   (done_o)
  );

  for (genvar t = 0; t < NUM_TONES; t++) begin : g_tone
    always_comb begin
      fcw_d[t] = fcw_q[t];
      if (accept) fcw_d[t] = fcw_in[t];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fcw_q[t] <= '0;
      else        fcw_q[t] <= fcw_d[t];
    end

    fsk_phase_acc #(.ACC_W(ACC_W)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (1'b1),
      .fcw_i   (fcw_q[t]),
      .phase_o (phase[t])
    );
  end

  assign tone_sel = bit_o ? TONE_HI : TONE_LO;
  assign lut_addr = phase[tone_sel][ACC_W-1 -: LUT_AW];

  fsk_sine_lut u_lut (
    .addr_i   (lut_addr),
    .sample_o (lut_val)
  );

  assign sample_o = busy_o ? lut_val : '0;
endmodule

// File: rtl/fsk_tx_chk.sv
module fsk_tx_chk #(
  parameter int unsigned ACC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [ACC_W-1:0] fcw_hi_q,
  input logic [ACC_W-1:0] fcw_lo_q,
  input logic [ACC_W-1:0] ph_hi,
  input logic [ACC_W-1:0] ph_lo
);
  a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  a_r7_settings_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(fcw_hi_q) && $stable(fcw_lo_q)));

  a_r5_hi_free_run: assert property (@(posedge clk) disable iff (!rst_n)
    ph_hi == ACC_W'($past(ph_hi) + $past(fcw_hi_q)));

  a_r5_lo_free_run: assert property (@(posedge clk) disable iff (!rst_n)
    ph_lo == ACC_W'($past(ph_lo) + $past(fcw_lo_q)));
endmodule

bind fsk_tx fsk_tx_chk #(.ACC_W(ACC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .fcw_hi_q (fcw_q[1]),
  .fcw_lo_q (fcw_q[0]),
  .ph_hi    (phase[1]),
  .ph_lo    (phase[0])
);

// File: tb/tb_fsk_tx.sv
module tb_fsk_tx;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] data;
  logic [15:0] fh, fl;
  logic [7:0]  len;
  logic signed [7:0] sample;
  logic        bit_s, busy, done;

  int checks = 0;
  int fails  = 0;
  bit summary_done = 0;

  always #5 clk = ~clk;

  fsk_tx dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .data_i(data),
    .fcw_hi_i(fh), .fcw_lo_i(fl), .bit_len_i(len),
    .sample_o(sample), .bit_o(bit_s), .busy_o(busy), .done_o(done)
  );

  typedef struct packed {
    logic [31:0] d;
    logic [15:0] h;
    logic [15:0] l;
    logic [7:0]  n;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{32'hA5C3_0F96, 16'h0C00, 16'h0400, 8'd4},
    '{32'hFFFF_0000, 16'h1000, 16'h0800, 8'd3},
    '{32'h1234_5678, 16'h2000, 16'h0200, 8'd1},
    '{32'h8000_0001, 16'h0A00, 16'h0500, 8'd0}
  };

  function automatic int sine_ref(int k);
    real x;
    x = 127.0 * $sin(2.0 * 3.14159265358979 * k / 64.0);
    if (x >= 0.0) return $rtoi(x + 0.5);
    else          return -$rtoi(-x + 0.5);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, built from the requirements
  logic [15:0] m_ah, m_al, m_fh, m_fl;
  logic [31:0] m_sh;
  logic [7:0]  m_len, m_sc;
  int          m_bc;
  logic        m_busy, m_done;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ah = '0; m_al = '0; m_fh = '0; m_fl = '0;
      m_sh = '0; m_len = 8'd1; m_sc = '0; m_bc = 0;
      m_busy = 1'b0; m_done = 1'b0;
    end else begin
      logic nd;
      m_ah = m_ah + m_fh;
      m_al = m_al + m_fl;
      nd = m_busy && (m_sc == m_len - 8'd1) && (m_bc == 31);
      if (m_busy) begin
        if (m_sc == m_len - 8'd1) begin
          m_sc = '0;
          if (m_bc == 31) m_busy = 1'b0;
          else begin m_bc++; m_sh = m_sh << 1; end
        end else m_sc++;
      end else if (start) begin
        m_busy = 1'b1; m_sh = data; m_sc = '0; m_bc = 0;
        m_len = (len == 8'd0) ? 8'd1 : len;
        m_fh = fh; m_fl = fl;
      end
      m_done = nd;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      int k;
      int es;
      k  = m_sh[31] ? int'(m_ah[15:10]) : int'(m_al[15:10]);
      es = m_busy ? sine_ref(k) : 0;
      chk("R4/R5 sample", int'(sample), es);
      chk("R3 bit", int'(bit_s), int'(m_busy & m_sh[31]));
      chk("R2 busy", int'(busy), int'(m_busy));
      chk("R6 done", int'(done), int'(m_done));
    end
  end

  task automatic drive(vec_t v);
    data = v.d; fh = v.h; fl = v.l; len = v.n;
  endtask

  // starts at a negedge, returns at the negedge where done is seen
  task automatic run_frame(vec_t v, bit intrude, output int busy_cycles);
    int guard;
    busy_cycles = 0;
    drive(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    while (!done && guard < 5000) begin
      if (busy) busy_cycles++;
      if (intrude && guard == 9) begin
        start = 1'b1; data = ~v.d; fh = 16'h3000; fl = 16'h0100; len = 8'd2;
      end else if (intrude && guard == 10) begin
        start = 1'b0;
      end
      guard++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!summary_done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      summary_done = 1;
    end
    $finish;
  end

  initial begin
    int bc;
    int exp_len;
    rst_n = 1'b0; start = 1'b0; data = '0; fh = '0; fl = '0; len = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset sample", int'(sample), 0);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset bit", int'(bit_s), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", int'(busy | done | bit_s), 0);

    // table-driven frames
    for (int i = 0; i < 4; i++) begin
      run_frame(VECS[i], 1'b0, bc);
      exp_len = (VECS[i].n == 8'd0) ? 32 : 32 * int'(VECS[i].n);
      if (VECS[i].n == 8'd0) chk("R9 zero length frame", bc, exp_len);
      else                   chk("R3 frame length", bc, exp_len);
      chk("R6 done with busy low", int'(busy), 0);
      @(negedge clk);
      chk("R6 done single cycle", int'(done), 0);
      chk("R6 idle zero output", int'(sample), 0);
    end

    // R7: start and new settings while busy are ignored
    run_frame(VECS[0], 1'b1, bc);
    chk("R7 ignored start keeps length", bc, 128);

    // R8: start in the done cycle is accepted
    drive(VECS[2]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8 back-to-back busy", int'(busy), 1);
    chk("R8 first bit of new word", int'(bit_s), int'(VECS[2].d[31]));
    while (!done) @(negedge clk);
    @(negedge clk);

    // R2: first bit MSB for a word with MSB set
    drive(VECS[3]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 msb first", int'(bit_s), 1);
    repeat (5) @(negedge clk);

    // R1: asynchronous reset mid-frame
    rst_n = 1'b0;
    #1;
    chk("R1 async busy", int'(busy), 0);
    chk("R1 async sample", int'(sample), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    if (!summary_done) begin
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      summary_done = 1;
    end
    $finish;
  end
endmodule